// File: doc/BRIEF.md
# Iterative Early-Out Integer Multiplier

This unit multiplies two 32-bit integers over several clock cycles. It can optionally add an accumulator and returns either a 32-bit or a 64-bit result. A one-cycle start pulse captures both operands, the accumulator and three mode selects:

- signed or unsigned interpretation,
- short (32-bit) or long (64-bit) result,
- accumulate enable.

The multiplier operand is consumed in 12-bit slices, one slice per cycle. The accumulator does not get its own final add. It is loaded as the starting partial sum, so it travels through the same carry-save array as the partial products.

Iteration stops as soon as every multiplier bit above the current slice is pure extension: copies of bit 31 in signed mode, or zeros in unsigned mode. Small multipliers therefore finish sooner.

A 32-bit adder then resolves the redundant sum and carry, 32 result bits per cycle. The low half comes first, and the high half follows on the next cycle when a long result was requested. The unit is meant to sit beside an integer pipeline. That pipeline issues a start, waits for the done pulse and then reads the held result.

Top module: `imul_early_out`

## Requirements
- R1: With acc_en_i low, result_o equals op_a_i times op_b_i. A long request returns all 64 bits. A short request returns the low 32 bits in result_o[31:0] with result_o[63:32] zero.
- R2: signed_i high treats both operands as two's complement. signed_i low treats them as unsigned. The product is exact modulo 2^64 in both cases.
- R3: Let k be the smallest value in 1..3 for which op_b_i bits 31 down to 12k all equal the extension bit (bit 31 when signed, 0 when unsigned); k is 3 when no smaller value qualifies. Count the edge that accepts start_i as edge 0. Then done_o is high after edge k+1 for a short result and after edge k+2 for a long one. This gives 2–4 cycles for short results and 3–5 for long ones.
- R4: With acc_en_i high, a long request adds all of acc_i to the product modulo 2^64. A short request adds acc_i[31:0] to the product modulo 2^32.
- R5: With acc_en_i low, acc_i has no effect on result_o.
- R6: busy_o is high from the accepting edge until the edge that raises done_o. busy_o is low while done_o is high, and busy_o and done_o are never high together.
- R7: A start_i pulse that arrives while busy_o is high is ignored. The running operation keeps its operands, modes and latency, and no further operation follows.
- R8: done_o is a one-cycle pulse. result_o does not change in any cycle in which busy_o was low at the previous edge.
- R9: While rst is high and after it is released, busy_o, done_o and result_o are zero until an operation is started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, accepted only while busy_o is low |
| signed_i | input | 1 | 1: two's complement operands, 0: unsigned |
| long_i | input | 1 | 1: 64-bit result, 0: 32-bit result |
| acc_en_i | input | 1 | 1: add acc_i to the product |
| op_a_i | input | 32 | Multiplicand |
| op_b_i | input | 32 | Multiplier, consumed 12 bits per cycle |
| acc_i | input | 64 | Accumulator (low 32 bits used for short results) |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 64 | Registered result, held between operations |

## Verification
The bench works out k from the multiplier's upper bits and mode. It expects done_o exactly k+1 edges after the accepting edge for a short result, and k+2 edges after it for a long one. Inputs are driven and outputs sampled on the falling edge, so every edge count is exact. The result is compared with a bench-computed 64-bit reference in the same cycle that done_o is seen. For ignored starts and idle holding, the bench waits three further cycles. It then confirms that no second done pulse appears and that result_o has not moved.

// File: rtl/imul_pkg.sv
package imul_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ITER = 2'd1,
    ST_LO   = 2'd2,
    ST_HI   = 2'd3
  } mul_state_e;
endpackage

// File: rtl/imul_short_detect.sv
// Selects the current multiplier slice and decides whether it is the last one.
module imul_short_detect #(
  parameter int SW = 12,
  parameter int NS = 3,
  parameter int BW = 36,
  parameter int IW = 2
) (
  input  logic [BW-1:0] b_ext_i,
  input  logic [IW-1:0] idx_i,
  output logic          last_o,
  output logic [SW:0]   digit_o
);
  logic signed [BW-1:0] rest;
  logic        [BW-1:0] shifted;
  logic                 ext;

  always_comb begin
    ext     = b_ext_i[BW-1];
    rest    = $signed(b_ext_i) >>> (SW * (int'(idx_i) + 1));
    shifted = b_ext_i >> (SW * int'(idx_i));
    last_o  = (rest == {BW{ext}}) || (int'(idx_i) == NS - 1);
    // the terminating slice carries the extension bit as its sign
    digit_o = {last_o ? ext : 1'b0, shifted[SW-1:0]};
  end
endmodule

// File: rtl/imul_csa_step.sv
// One array cycle: partial product for a signed digit, folded in by 3:2 compression.
module imul_csa_step #(
  parameter int PW = 64,
  parameter int SW = 12,
  parameter int IW = 2
) (
  input  logic [PW-1:0] a_ext_i,
  input  logic [SW:0]   digit_i,
  input  logic [IW-1:0] idx_i,
  input  logic [PW-1:0] sum_i,
  input  logic [PW-1:0] car_i,
  output logic [PW-1:0] sum_o,
  output logic [PW-1:0] car_o
);
  logic [PW-1:0] dig_ext, pp, maj;

  always_comb begin
    dig_ext = {{(PW-SW-1){digit_i[SW]}}, digit_i};
    pp      = (a_ext_i * dig_ext) << (SW * int'(idx_i));
  end

  for (genvar k = 0; k < PW; k++) begin : g_fa
    assign sum_o[k] = sum_i[k] ^ car_i[k] ^ pp[k];
    assign maj[k]   = (sum_i[k] & car_i[k]) | (sum_i[k] & pp[k]) | (car_i[k] & pp[k]);
  end

  assign car_o = {maj[PW-2:0], 1'b0};
endmodule

// File: rtl/imul_half_add.sv
// Resolving adder, one result half per cycle.
module imul_half_add #(
  parameter int HW = 32
) (
  input  logic [HW-1:0] a_i,
  input  logic [HW-1:0] b_i,
  input  logic          cin_i,
  output logic [HW-1:0] sum_o,
  output logic          cout_o
);
  assign {cout_o, sum_o} = {1'b0, a_i} + {1'b0, b_i} + {{HW{1'b0}}, cin_i};
endmodule

// File: rtl/imul_early_out.sv
module imul_early_out
  import imul_pkg::*;
#(
  parameter int DW = 32,
  parameter int SW = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start_i,
  input  logic            signed_i,
  input  logic            long_i,
  input  logic            acc_en_i,
  input  logic [DW-1:0]   op_a_i,
  input  logic [DW-1:0]   op_b_i,
  input  logic [2*DW-1:0] acc_i,
  output logic            busy_o,
  output logic            done_o,
  output logic [2*DW-1:0] result_o
);
  localparam int NS = (DW + SW - 1) / SW;
  localparam int BW = NS * SW;
  localparam int PW = 2 * DW;
  localparam int IW = $clog2(NS + 1);

  mul_state_e    state_q;
  logic [PW-1:0] a_q, sum_q, car_q, sum_n, car_n, res_q;
  logic [BW-1:0] b_q;
  logic [IW-1:0] idx_q;
  logic          long_q, cy_q, busy_q, done_q;
  logic          last_w;
  logic [SW:0]   digit_w;
  logic [DW-1:0] add_a, add_b, add_s;
  logic          add_cin, add_co;

  imul_short_detect #(.SW(SW), .NS(NS), .BW(BW), .IW(IW)) u_det (
    .b_ext_i(b_q), .idx_i(idx_q), .last_o(last_w), .digit_o(digit_w)
  );

  imul_csa_step #(.PW(PW), .SW(SW), .IW(IW)) u_csa (
    .a_ext_i(a_q), .digit_i(digit_w), .idx_i(idx_q),
    .sum_i(sum_q), .car_i(car_q), .sum_o(sum_n), .car_o(car_n)
  );

  always_comb begin
    if (state_q == ST_HI) begin
      add_a   = sum_q[PW-1:DW];
      add_b   = car_q[PW-1:DW];
      add_cin = cy_q;
    end else begin
      add_a   = sum_q[DW-1:0];
      add_b   = car_q[DW-1:0];
      add_cin = 1'b0;
    end
  end

  imul_half_add #(.HW(DW)) u_add (
    .a_i(add_a), .b_i(add_b), .cin_i(add_cin), .sum_o(add_s), .cout_o(add_co)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      a_q     <= '0;
      b_q     <= '0;
      sum_q   <= '0;
      car_q   <= '0;
      idx_q   <= '0;
      long_q  <= 1'b0;
      cy_q    <= 1'b0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      res_q   <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            a_q    <= signed_i ? {{DW{op_a_i[DW-1]}}, op_a_i} : {{DW{1'b0}}, op_a_i};
            b_q    <= signed_i ? {{(BW-DW){op_b_i[DW-1]}}, op_b_i}
                               : {{(BW-DW){1'b0}}, op_b_i};
            // accumulator enters the array as the initial partial sum
            if (!acc_en_i)    sum_q <= '0;
            else if (long_i)  sum_q <= acc_i;
            else              sum_q <= {{DW{1'b0}}, acc_i[DW-1:0]};
            car_q   <= '0;
            idx_q   <= '0;
            long_q  <= long_i;
            busy_q  <= 1'b1;
            state_q <= ST_ITER;
          end
        end
        ST_ITER: begin
          sum_q <= sum_n;
          car_q <= car_n;
          if (last_w) state_q <= ST_LO;
          else        idx_q   <= idx_q + 1'b1;
        end
        ST_LO: begin
          res_q[DW-1:0] <= add_s;
          cy_q          <= add_co;
          if (long_q) begin
            state_q <= ST_HI;
          end else begin
            res_q[PW-1:DW] <= '0;
            done_q  <= 1'b1;
            busy_q  <= 1'b0;
            state_q <= ST_IDLE;
          end
        end
        ST_HI: begin
          res_q[PW-1:DW] <= add_s;
          done_q  <= 1'b1;
          busy_q  <= 1'b0;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o   = busy_q;
  assign done_o   = done_q;
  assign result_o = res_q;

  // latency monitor for the checks below
  logic [3:0] lat_q;
  always_ff @(posedge clk) begin
    if (rst)                     lat_q <= '0;
    else if (start_i && !busy_q) lat_q <= '0;
    else if (busy_q)             lat_q <= lat_q + 1'b1;
  end

  // R3
  latency_range_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (long_q ? (int'(lat_q) >= 3 && int'(lat_q) <= NS + 2)
                       : (int'(lat_q) >= 2 && int'(lat_q) <= NS + 1)))
    else $error("latency out of range");

  // R6
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(busy_o && done_o)) else $error("busy and done together");

  // R6
  done_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> $past(busy_o)) else $error("done without busy");

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o) else $error("done longer than one cycle");

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !busy_o |=> $stable(result_o)) else $error("result moved while idle");
endmodule

// File: tb/imul_early_out_tb.sv
`timescale 1ns/1ps
module imul_early_out_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0, signed_i = 1'b0, long_i = 1'b0, acc_en_i = 1'b0;
  logic [31:0] op_a_i = '0, op_b_i = '0;
  logic [63:0] acc_i = '0;
  logic        busy_o, done_o;
  logic [63:0] result_o;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  imul_early_out dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .signed_i(signed_i),
    .long_i(long_i), .acc_en_i(acc_en_i), .op_a_i(op_a_i), .op_b_i(op_b_i),
    .acc_i(acc_i), .busy_o(busy_o), .done_o(done_o), .result_o(result_o)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] ref_result(input logic [31:0] a, b,
      input logic [63:0] acc, input logic ae, sg, lg);
    logic [63:0] ax, bx, p;
    ax = sg ? {{32{a[31]}}, a} : {32'b0, a};
    bx = sg ? {{32{b[31]}}, b} : {32'b0, b};
    p  = ax * bx;
    if (ae) p = p + acc;
    return lg ? p : {32'b0, p[31:0]};
  endfunction

  function automatic int ref_slices(input logic [31:0] b, input logic sg);
    logic ext;
    ext = sg ? b[31] : 1'b0;
    for (int k = 1; k < 3; k++) begin
      bit all_ext = 1;
      for (int j = 12 * k; j < 32; j++) if (b[j] != ext) all_ext = 0;
      if (all_ext) return k;
    end
    return 3;
  endfunction

  task automatic run_op(input logic [31:0] a, b, input logic [63:0] acc,
                        input logic ae, sg, lg, input bit inject, input string tag);
    int lat;
    bit busy_ok;
    logic [63:0] exp, held;
    int exp_lat;
    exp     = ref_result(a, b, acc, ae, sg, lg);
    exp_lat = ref_slices(b, sg) + 1 + (lg ? 1 : 0);
    @(negedge clk);
    op_a_i = a; op_b_i = b; acc_i = acc; acc_en_i = ae; signed_i = sg; long_i = lg;
    start_i = 1'b1;
    @(negedge clk);
    lat = 0;
    busy_ok = busy_o;
    start_i = 1'b0;
    if (inject) begin
      // R7: foreign start while busy
      start_i = 1'b1; op_a_i = ~a; op_b_i = b ^ 32'h5A5A_00FF;
      signed_i = ~sg; long_i = ~lg; acc_en_i = ~ae; acc_i = ~acc;
    end
    while (!done_o && lat < 16) begin
      @(negedge clk);
      start_i = 1'b0;
      lat++;
      if (!done_o && !busy_o) busy_ok = 0;
    end
    // R1 R2 R4 R5
    check(result_o == exp, {"R1/R2/R4/R5 result ", tag}, result_o, exp);
    // R3
    check(lat == exp_lat, {"R3 latency ", tag}, 64'(lat), 64'(exp_lat));
    // R6
    check(busy_ok && !busy_o, {"R6 busy ", tag}, {63'b0, busy_o}, 64'd0);
    if (inject) begin
      bit extra = 0;
      held = result_o;
      for (int i = 0; i < 3; i++) begin
        @(negedge clk);
        if (done_o || busy_o) extra = 1;
      end
      // R7
      check(!extra && result_o == held, {"R7 ignored start ", tag}, result_o, held);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] corners [8];
    void'($urandom(32'd20240611));
    corners = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h8000_0000, 32'h7FFF_FFFF,
                32'h0000_0FFF, 32'hFFFF_F800, 32'h00FF_FFFF};
    repeat (3) @(negedge clk);
    // R9: reset values while rst high
    check(!busy_o && !done_o && result_o == 64'd0, "R9 reset", result_o, 64'd0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check(!busy_o && !done_o && result_o == 64'd0, "R9 after release", result_o, 64'd0);

    // directed corners, every mode
    for (int m = 0; m < 8; m++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j += 3)
          run_op(corners[i], corners[(i + j) % 8], 64'hF0E1_D2C3_B4A5_9687,
                 m[0], m[1], m[2], 1'b0, "corner");

    // R5: acc ignored when disabled, with two different accumulators
    run_op(32'h1234_5678, 32'h9ABC_DEF0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b0, 1'b1, 1'b0, "R5 acc off A");
    run_op(32'h1234_5678, 32'h9ABC_DEF0, 64'h0000_0001_0000_0001, 1'b0, 1'b0, 1'b1, 1'b0, "R5 acc off B");

    // R3 boundaries of each slice count
    run_op(32'hDEAD_BEEF, 32'h0000_0FFF, 64'd0, 1'b0, 1'b0, 1'b0, 1'b0, "R3 k1 unsigned");
    run_op(32'hDEAD_BEEF, 32'h0000_1000, 64'd0, 1'b0, 1'b0, 1'b0, 1'b0, "R3 k2 unsigned");
    run_op(32'hDEAD_BEEF, 32'h0100_0000, 64'd0, 1'b0, 1'b0, 1'b1, 1'b0, "R3 k3 unsigned");
    run_op(32'hDEAD_BEEF, 32'hFFFF_F000, 64'd0, 1'b0, 1'b1, 1'b1, 1'b0, "R3 k1 signed");
    run_op(32'hDEAD_BEEF, 32'hFFFF_F000, 64'd0, 1'b0, 1'b0, 1'b1, 1'b0, "R3 k3 unsigned neg");

    // R7: foreign start during operation
    run_op(32'h8000_0001, 32'h7FFF_FFFF, 64'h5, 1'b1, 1'b1, 1'b1, 1'b1, "R7 long");
    run_op(32'hFFFF_FFFE, 32'h0000_0003, 64'h9, 1'b1, 1'b1, 1'b0, 1'b1, "R7 short");

    // R8: result held while idle
    begin
      logic [63:0] held;
      bit moved = 0;
      held = result_o;
      for (int i = 0; i < 5; i++) begin
        @(negedge clk);
        if (result_o != held || done_o) moved = 1;
      end
      check(!moved, "R8 hold", result_o, held);
    end

    // random operands with mixed multiplier magnitudes
    for (int n = 0; n < 400; n++) begin
      logic [31:0] a, b;
      logic [63:0] acc;
      int sel;
      a   = $urandom;
      acc = {$urandom, $urandom};
      sel = $urandom_range(0, 3);
      case (sel)
        0: b = $urandom_range(0, 4095);
        1: b = $urandom & 32'h00FF_FFFF;
        2: b = 32'hFFFF_FFFF - $urandom_range(0, 8191);
        default: b = $urandom;
      endcase
      run_op(a, b, acc, 1'($urandom), 1'($urandom), 1'($urandom),
             (n % 37) == 0, "random");
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule